// File: doc/BRIEF.md
# SPI Target Port with Shared-Line MISO and Low-Phase Watchdog

This block is the target (slave) side of a four-wire SPI link. It runs entirely on the system clock and oversamples chip-select, serial clock and the incoming data line through synchronizer chains. Serial-clock transitions are then detected in the system clock domain. Two static inputs choose the clock polarity and phase. Together they decide which serial-clock edge samples MOSI and which edge moves the next MISO bit out. Each frame is a fixed number of bits, most significant bit first.

When chip-select falls, the block captures a transmit word. It enables its MISO driver only while selected, so several targets can share one MISO wire through an external tristate pad. A completed frame is handed to user logic as a one-cycle valid strobe with the received word. A frame that is cut short is reported with a one-cycle error strobe instead. A frame can be cut short in two ways: chip-select rises early, or the serial clock rests low for too long while the frame is partly received. In the second case the partial data is discarded.

Top module: `spi_target_port`

## Requirements
- R1: After reset, miso_oe, miso, rx_valid and rx_err are 0 and rx_data is all zeros.
- R2: miso_oe and miso are 0 whenever chip-select has been high for three system clocks. miso_oe is 1 whenever it has been low for three system clocks.
- R3: tx_data is captured in the same cycle that miso_oe rises. Its MSB is on miso before the first serial-clock edge. Later changes of tx_data have no effect on the frame being sent.
- R4: The leading edge is the rising serial-clock edge when cpol=0 and the falling edge when cpol=1. With cpha=0, MOSI is sampled on leading edges and MISO advances on trailing edges. With cpha=1, MISO advances on leading edges, except the first leading edge of a frame, and MOSI is sampled on trailing edges.
- R5: After WORD_W sampled bits, rx_valid is 1 for exactly one cycle. rx_data then holds the bits in arrival order, first bit in the MSB, and keeps them until the next completed frame.
- R6: miso presents the captured word MSB first, one bit per advancing edge.
- R7: If chip-select rises after 1 to WORD_W-1 bits of a frame, rx_err pulses for one cycle and rx_valid stays 0. The next selection starts again at bit zero.
- R8: If the synchronized serial clock is low for TMO_CYC consecutive system clocks while selected and at least one bit of the current frame has been sampled, rx_err pulses once. The partial word is dropped. Further edges until chip-select rises produce neither rx_valid nor a second rx_err. A low phase shorter than TMO_CYC has no effect.
- R9: A low rest or a chip-select rise with zero bits received in the current frame raises no rx_err.
- R10: Every pin change takes effect on the outputs at the third rising system clock edge after the edge that first samples it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cpol | input | 1 | Serial clock idle level (static) |
| cpha | input | 1 | 0: sample on leading edge, 1: sample on trailing edge (static) |
| scs_n | input | 1 | Chip-select, active low, asynchronous |
| sclk | input | 1 | Serial clock, asynchronous, at most a quarter of clk |
| mosi | input | 1 | Serial data from the controller |
| tx_data | input | WORD_W | Word to send, captured when selected |
| miso | output | 1 | Serial data to the controller, 0 when not driven |
| miso_oe | output | 1 | MISO pad driver enable |
| rx_data | output | WORD_W | Last completed received word |
| rx_valid | output | 1 | One-cycle strobe for a completed frame |
| rx_err | output | 1 | One-cycle strobe for an aborted frame |

## Verification
Every result is due three rising system clock edges after the pin change is first sampled: two synchronizer flops and then the register that acts on the detected edge. The bench drives pins on falling clock edges and holds each serial-clock half period for four system clocks, so each MISO bit and each sampled MOSI bit has settled before the bench looks at it. The enable latency is probed cycle by cycle: still off two falling edges after the drive, on at the third. The single-cycle valid and error strobes are counted by a monitor on the falling clock edge, so no pulse is missed between checks.

// File: rtl/spi_tgt_pkg.sv
package spi_tgt_pkg;

    // Depth of each input synchronizer chain
    localparam int SYNC_DEPTH = 2;

    typedef struct packed {
        logic cpol;
        logic cpha;
    } spi_mode_t;

    // Per-cycle events seen in the system clock domain
    typedef struct packed {
        logic sel;      // target currently selected
        logic cs_fall;  // selection begins this cycle
        logic cs_rise;  // selection ends this cycle
        logic sample;   // capture MOSI this cycle
        logic shift;    // advance MISO this cycle
    } spi_evt_t;

    function automatic logic lead_edge(spi_mode_t m, logic rise, logic fall);
        return m.cpol ? fall : rise;
    endfunction

    function automatic logic trail_edge(spi_mode_t m, logic rise, logic fall);
        return m.cpol ? rise : fall;
    endfunction

endpackage

// File: rtl/spi_tgt_sync.sv
module spi_tgt_sync #(
    parameter int N = 3,
    parameter int STAGES = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] d_in,
    output logic [N-1:0] d_out
);
    logic [STAGES-1:0][N-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d_in;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign d_out = stg[STAGES-1];
endmodule

// File: rtl/spi_tgt_edge.sv
module spi_tgt_edge
    import spi_tgt_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  spi_mode_t mode,
    input  logic      scs_s,
    input  logic      sclk_s,
    output spi_evt_t  evt
);
    logic sclk_d;
    logic scs_d;
    logic rise;
    logic fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d <= 1'b0;
            scs_d  <= 1'b1;
        end else begin
            sclk_d <= sclk_s;
            scs_d  <= scs_s;
        end
    end

    assign rise = sclk_s & ~sclk_d;
    assign fall = ~sclk_s & sclk_d;

    always_comb begin
        evt.sel     = ~scs_s;
        evt.cs_fall = scs_d & ~scs_s;
        evt.cs_rise = scs_s & ~scs_d;
        if (mode.cpha) begin
            evt.sample = ~scs_s & trail_edge(mode, rise, fall);
            evt.shift  = ~scs_s & lead_edge(mode, rise, fall);
        end else begin
            evt.sample = ~scs_s & lead_edge(mode, rise, fall);
            evt.shift  = ~scs_s & trail_edge(mode, rise, fall);
        end
    end
endmodule

// File: rtl/spi_tgt_tmo.sv
module spi_tgt_tmo #(
    parameter int TMO_CYC = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic sel,
    input  logic sclk_s,
    output logic tmo_hit
);
    localparam int TW = $clog2(TMO_CYC + 1);

    logic [TW-1:0] low_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt <= '0;
        end else if (!sel || sclk_s) begin
            low_cnt <= '0;
        end else if (low_cnt != TW'(TMO_CYC)) begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    // Fires once, on the TMO_CYC-th consecutive low cycle
    assign tmo_hit = sel && !sclk_s && (low_cnt == TW'(TMO_CYC - 1));
endmodule

// File: rtl/spi_tgt_shift.sv
module spi_tgt_shift
    import spi_tgt_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpha,
    input  spi_evt_t          evt,
    input  logic              mosi_s,
    input  logic              tmo_hit,
    input  logic [WORD_W-1:0] tx_data,
    output logic              miso,
    output logic              miso_oe,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_err
);
    localparam int CW = (WORD_W > 1) ? $clog2(WORD_W) : 1;

    logic [WORD_W-1:0] tx_sr;
    logic [WORD_W-1:0] rx_sr;
    logic [CW-1:0]     bit_cnt;
    logic              hold_first;
    logic              aborted;
    logic              oe_q;
    logic [WORD_W-1:0] rx_next;

    assign rx_next = {rx_sr[WORD_W-2:0], mosi_s};

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_sr      <= '0;
            rx_sr      <= '0;
            rx_data    <= '0;
            bit_cnt    <= '0;
            hold_first <= 1'b0;
            aborted    <= 1'b0;
            oe_q       <= 1'b0;
            rx_valid   <= 1'b0;
            rx_err     <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            rx_err   <= 1'b0;
            oe_q     <= evt.sel;
            if (!evt.sel) begin
                if (evt.cs_rise && bit_cnt != '0 && !aborted) rx_err <= 1'b1;
                bit_cnt <= '0;
                aborted <= 1'b0;
            end else if (evt.cs_fall) begin
                tx_sr      <= tx_data;
                hold_first <= cpha;
                bit_cnt    <= '0;
                aborted    <= 1'b0;
            end else if (!aborted) begin
                if (tmo_hit && bit_cnt != '0) begin
                    aborted <= 1'b1;
                    rx_err  <= 1'b1;
                    bit_cnt <= '0;
                end else begin
                    if (evt.shift) begin
                        if (hold_first) hold_first <= 1'b0;
                        else            tx_sr <= {tx_sr[WORD_W-2:0], 1'b0};
                    end
                    if (evt.sample) begin
                        rx_sr <= rx_next;
                        if (bit_cnt == CW'(WORD_W - 1)) begin
                            rx_data  <= rx_next;
                            rx_valid <= 1'b1;
                            bit_cnt  <= '0;
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                end
            end
        end
    end

    assign miso_oe = oe_q;
    assign miso    = oe_q & tx_sr[WORD_W-1];
endmodule

// File: rtl/spi_target_port.sv
module spi_target_port
    import spi_tgt_pkg::*;
#(
    parameter int WORD_W  = 8,
    parameter int TMO_CYC = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              scs_n,
    input  logic              sclk,
    input  logic              mosi,
    input  logic [WORD_W-1:0] tx_data,
    output logic              miso,
    output logic              miso_oe,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_err
);
    logic [2:0] pins_s;
    spi_mode_t  mode;
    spi_evt_t   evt;
    logic       tmo_hit;

    assign mode = '{cpol: cpol, cpha: cpha};

    spi_tgt_sync #(
        .N(3), .STAGES(SYNC_DEPTH), .RST_VAL(3'b100)
    ) u_sync (
        .clk(clk), .rst(rst),
        .d_in({scs_n, sclk, mosi}),
        .d_out(pins_s)
    );

    spi_tgt_edge u_edge (
        .clk(clk), .rst(rst), .mode(mode),
        .scs_s(pins_s[2]), .sclk_s(pins_s[1]),
        .evt(evt)
    );

    spi_tgt_tmo #(.TMO_CYC(TMO_CYC)) u_tmo (
        .clk(clk), .rst(rst),
        .sel(evt.sel), .sclk_s(pins_s[1]),
        .tmo_hit(tmo_hit)
    );

    spi_tgt_shift #(.WORD_W(WORD_W)) u_shift (
        .clk(clk), .rst(rst), .cpha(cpha), .evt(evt),
        .mosi_s(pins_s[0]), .tmo_hit(tmo_hit), .tx_data(tx_data),
        .miso(miso), .miso_oe(miso_oe),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_err(rx_err)
    );
endmodule

// File: rtl/spi_target_port_chk.sv
module spi_target_port_chk (
    input logic clk,
    input logic rst,
    input logic scs_n,
    input logic miso,
    input logic miso_oe,
    input logic rx_valid,
    input logic rx_err
);
    logic [1:0] since_rst;
    logic       warm;

    always_ff @(posedge clk) begin
        if (rst) since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 1'b1;
    end
    assign warm = (since_rst == 2'd3);

    // R2 R10
    oe_follows_cs_chk: assert property (@(posedge clk) disable iff (rst)
        warm |-> (miso_oe == !$past(scs_n, 3)));

    // R2
    miso_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !miso_oe |-> !miso);

    // R5
    valid_single_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    // R8
    err_single_chk: assert property (@(posedge clk) disable iff (rst)
        rx_err |=> !rx_err);

    // R7
    valid_err_apart_chk: assert property (@(posedge clk) disable iff (rst)
        !(rx_valid && rx_err));
endmodule

bind spi_target_port spi_target_port_chk u_chk (
    .clk(clk), .rst(rst), .scs_n(scs_n), .miso(miso),
    .miso_oe(miso_oe), .rx_valid(rx_valid), .rx_err(rx_err)
);

// File: tb/spi_target_port_test.sv
module spi_target_port_test;
    localparam int W    = 8;
    localparam int TMO  = 32;
    localparam int HALF = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cpol = 1'b0, cpha = 1'b0, scs_n = 1'b1, sclk = 1'b0, mosi = 1'b0;
    logic [W-1:0] tx_data = '0;
    logic miso, miso_oe, rx_valid, rx_err;
    logic [W-1:0] rx_data;

    always #2 clk = ~clk;

    spi_target_port #(.WORD_W(W), .TMO_CYC(TMO)) uut (
        .clk(clk), .rst(rst), .cpol(cpol), .cpha(cpha), .scs_n(scs_n),
        .sclk(sclk), .mosi(mosi), .tx_data(tx_data), .miso(miso),
        .miso_oe(miso_oe), .rx_data(rx_data), .rx_valid(rx_valid), .rx_err(rx_err)
    );

    int total = 0, bad = 0, n_valid = 0, n_err = 0, bidx = 0;
    logic [W-1:0] m_cur, got;
    logic [W-1:0] tx_cur;

    // {cpol, cpha, tx word, mosi word}
    localparam logic [17:0] VEC [8] = '{
        {2'b00, 8'hA5, 8'h3C}, {2'b01, 8'h5A, 8'hC3},
        {2'b10, 8'hF0, 8'h0F}, {2'b11, 8'h81, 8'h7E},
        {2'b00, 8'hFF, 8'h00}, {2'b01, 8'h00, 8'hFF},
        {2'b10, 8'h96, 8'h69}, {2'b11, 8'h01, 8'h80}
    };

    always @(negedge clk) begin
        if (!rst) begin
            if (rx_valid) n_valid++;
            if (rx_err)   n_err++;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic start(input logic pol, input logic pha, input logic [W-1:0] tx, input logic [W-1:0] m);
        cpol = pol; cpha = pha; sclk = pol;
        wait_n(6);
        scs_n = 1'b0; tx_data = tx; tx_cur = tx; m_cur = m; bidx = W - 1; got = '0;
        wait_n(HALF);
        tx_data = ~tx;   // must not affect the frame (R3)
    endtask

    task automatic clk_bits(input int n);
        for (int i = 0; i < n; i++) begin
            if (!cpha) begin
                mosi = m_cur[bidx]; got[bidx] = miso;
                sclk = ~sclk; wait_n(HALF);
                sclk = ~sclk; wait_n(HALF);
            end else begin
                sclk = ~sclk; wait_n(HALF);
                mosi = m_cur[bidx]; got[bidx] = miso;
                sclk = ~sclk; wait_n(HALF);
            end
            bidx--;
        end
    endtask

    task automatic stop();
        wait_n(HALF);
        scs_n = 1'b1;
        wait_n(6);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL R10 watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int v0, e0;
        wait_n(5);
        // R1 reset state
        check("R1 miso_oe", miso_oe, 0);
        check("R1 miso", miso, 0);
        check("R1 rx_valid", rx_valid, 0);
        check("R1 rx_err", rx_err, 0);
        check("R1 rx_data", rx_data, 0);
        rst = 1'b0;
        wait_n(5);

        // R10 / R2: enable latency on select and deselect
        scs_n = 1'b0; tx_data = 8'h80;
        wait_n(2); check("R10 oe still off", miso_oe, 0);
        wait_n(1); check("R10 oe on", miso_oe, 1);
        check("R3 msb ready", miso, 1);
        scs_n = 1'b1;
        wait_n(2); check("R10 oe still on", miso_oe, 1);
        wait_n(1); check("R2 oe off", miso_oe, 0);
        check("R2 miso low", miso, 0);
        wait_n(4);
        check("R9 no err on empty select", n_err, 0);

        // Table of frames over all four modes (R4 R5 R6 R3)
        foreach (VEC[k]) begin
            v0 = n_valid; e0 = n_err;
            start(VEC[k][17], VEC[k][16], VEC[k][15:8], VEC[k][7:0]);
            check("R2 oe during frame", miso_oe, 1);
            clk_bits(W);
            stop();
            check("R5 one valid", n_valid - v0, 1);
            check("R5 no err", n_err - e0, 0);
            check("R4 R5 rx_data", rx_data, VEC[k][7:0]);
            check("R3 R6 miso bits", got, VEC[k][15:8]);
            check("R2 oe off after", miso_oe, 0);
        end

        // R7: early chip-select rise, then clean restart
        v0 = n_valid; e0 = n_err;
        start(1'b0, 1'b1, 8'h3C, 8'hE7);
        clk_bits(3);
        stop();
        check("R7 err on short frame", n_err - e0, 1);
        check("R7 no valid", n_valid - v0, 0);
        check("R7 rx_data kept", rx_data, VEC[7][7:0]);
        start(1'b0, 1'b1, 8'h3C, 8'h5B);
        clk_bits(W);
        stop();
        check("R7 restart valid", n_valid - v0, 1);
        check("R7 restart data", rx_data, 8'h5B);

        // R8: short stall is harmless
        v0 = n_valid; e0 = n_err;
        start(1'b0, 1'b0, 8'hC6, 8'h2D);
        clk_bits(3);
        wait_n(TMO - 2*HALF - 4);
        clk_bits(5);
        stop();
        check("R8 short stall valid", n_valid - v0, 1);
        check("R8 short stall data", rx_data, 8'h2D);
        check("R8 short stall no err", n_err - e0, 0);

        // R8: long stall aborts and rest of frame ignored
        v0 = n_valid; e0 = n_err;
        start(1'b0, 1'b0, 8'hC6, 8'hB4);
        clk_bits(3);
        wait_n(TMO + 8);
        check("R8 timeout err", n_err - e0, 1);
        clk_bits(5);
        stop();
        check("R8 no valid after abort", n_valid - v0, 0);
        check("R8 single err", n_err - e0, 1);
        check("R8 data kept", rx_data, 8'h2D);

        // R9: long low rest with no bits
        e0 = n_err;
        start(1'b0, 1'b0, 8'h11, 8'h22);
        wait_n(2*TMO);
        stop();
        check("R9 no err on idle timeout", n_err - e0, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule